// File: doc/BRIEF.md
# SCSI Initiator Phase Handshake Sequencer

This block is the initiator-side phase machine of a SCSI controller. Once selection has been won, it walks the bus through the command, data-in, data-out, status, message-in and message-out phases, one REQ/ACK byte exchange at a time. A register block above it issues single-cycle "assert ACK" (set) and "release ACK" (clear) strokes and passes the outbound byte. The sequencer holds the phase-sense image that software reads. On every stroke it checks the image against the phase that software has programmed as expected.

On the other side sits a simple target model. It tells the sequencer where to go after a command, how many bytes each data block carries, and whether another block follows. It also supplies the data-in, status and message bytes. The command descriptor block is captured into a small memory with a registered read port. Its length is decided from the opcode group of the first byte. While ATN is raised, the sequencer steers the bus into message-out and remembers the phase it interrupted.

Top module: `scsi_phase_seq`

## Requirements
- R1: After synchronous reset, `sense_o` reads 0x00 with ATN low. All byte outputs are 0x00 and all pulse outputs are 0.
- R2: `sense_o` bit positions are: 0 I/O, 1 C/D, 2 MSG, 3 BSY, 4 SEL, 5 ATN, 6 ACK, 7 REQ. Bits [2:0] hold the phase code: data-out 000, data-in 001, command 010, status 011, message-out 110, message-in 111. Bit 5 shows `atn_i` one cycle after it changes. REQ and ACK are never both 1.
- R3: `start_i` on a free bus enters the command phase with sense 0x8A (REQ|BSY|command). If ATN is already high, it enters message-out instead (0x8E plus ATN) and keeps command as the phase to resume.
- R4: A set stroke takes effect only when REQ and BSY are both 1 and `expect_phase_i` equals sense [2:0]. It then drives sense to ACK|BSY|phase. A refused set stroke while I/O is 1 returns 0xFF on `rd_byte_o`.
- R5: A clear stroke takes effect only when ACK and BSY are both 1 and the phase matches. A refused stroke of either kind with a phase mismatch while `xfer_active_i` is 1 pulses `phase_err_o`. A refused stroke leaves sense unchanged.
- R6: The first command byte fixes the command length: opcode below 0x20 gives 6 bytes, below 0xA0 gives 10, otherwise 12. Bytes are stored at addresses 0 upward and read back on `cdb_raddr_i`/`cdb_rdata_o` one cycle later. `cmd_done_o` pulses on the clear stroke of the last byte only.
- R7: After the last command byte, if `tgt_exec_i` is 1, sense shows only BSY (0x08). Each `sense_rd_i` strobe re-polls the target. Once `tgt_exec_i` is 0, the strobe moves to the phase on `tgt_phase_i`: 000 data-out, 001 data-in, anything else status.
- R8: A data phase takes exactly `tgt_count_i` clear strokes. At the last one, if `tgt_more_i` is 1, a new count is loaded, `blk_req_o` pulses and the phase stays. Otherwise the bus moves to status (0x8B).
- R9: The clear stroke in status moves to message-in (0x8F). The clear stroke in message-in with `tgt_msg_pend_i` low frees the bus: sense becomes 0x00 and `disc_o` pulses. `release_i` frees the bus the same way from any phase.
- R10: When ATN is high at the end of a clear stroke, the sequencer enters message-out instead of the new phase. A clear stroke in message-out with ATN low resumes the saved phase, keeping the remaining data byte count.
- R11: In data-out and message-out, a set stroke puts `wr_byte_i` on `out_byte_o` with an `out_stb_o` pulse. In data-in, a set stroke puts `tgt_data_i` on `rd_byte_o` with an `in_pop_o` pulse. In status and message-in, it returns `tgt_status_i` and `tgt_msg_i` respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| atn_i | input | 1 | ATN request level from the register block |
| start_i | input | 1 | Selection won; begin the command phase |
| release_i | input | 1 | Force bus release |
| set_req_i | input | 1 | Set (assert ACK) stroke |
| clr_req_i | input | 1 | Clear (release ACK) stroke |
| sense_rd_i | input | 1 | Phase-sense read strobe; resolves the executing state |
| xfer_active_i | input | 1 | A programmed transfer is in progress |
| expect_phase_i | input | 3 | Phase code software expects |
| wr_byte_i | input | 8 | Outbound byte for the set stroke |
| tgt_exec_i | input | 1 | Target still executing the command |
| tgt_phase_i | input | 3 | Phase the target picks after the command |
| tgt_count_i | input | CNT_W | Bytes in the next data block |
| tgt_more_i | input | 1 | Another data block is available |
| tgt_data_i | input | 8 | Data-in byte from the target |
| tgt_status_i | input | 8 | Status byte from the target |
| tgt_msg_i | input | 8 | Message-in byte from the target |
| tgt_msg_pend_i | input | 1 | Target has a further message to send |
| cdb_raddr_i | input | IDX_W | Command byte read address |
| sense_o | output | 8 | Phase-sense image with ATN in bit 5 |
| rd_byte_o | output | 8 | Byte returned by the last set stroke |
| out_byte_o | output | 8 | Byte sent to the target |
| out_stb_o | output | 1 | Pulse: `out_byte_o` was sent |
| in_pop_o | output | 1 | Pulse: a data-in byte was taken |
| blk_req_o | output | 1 | Pulse: a further data block was started |
| cmd_done_o | output | 1 | Pulse: the last command byte was handed over |
| phase_err_o | output | 1 | Pulse: phase mismatch during a transfer |
| disc_o | output | 1 | Pulse: bus freed (disconnected) |
| cdb_rdata_o | output | 8 | Stored command byte at `cdb_raddr_i` |

## Verification
The bench builds the block with its default parameters: a 16-bit byte counter and a 12-entry command store. The store is just deep enough for the longest opcode group, so the 12-byte command fills it exactly. The bench drives data blocks of one to three bytes, which puts both the mid-block and block-end counter paths within a few strokes. The opcode boundaries 0x1F, 0x20 and 0xA0 each reach a different command length.

// File: rtl/scsi_seq_pkg.sv
`timescale 1ns/1ps
package scsi_seq_pkg;

  // sense bit positions
  localparam int SB_IO  = 0;
  localparam int SB_CD  = 1;
  localparam int SB_MSG = 2;
  localparam int SB_BSY = 3;
  localparam int SB_ATN = 5;
  localparam int SB_ACK = 6;
  localparam int SB_REQ = 7;

  // sequencer state; low three bits equal the bus phase code
  typedef enum logic [3:0] {
    PH_DOUT = 4'h0,
    PH_DIN  = 4'h1,
    PH_CMD  = 4'h2,
    PH_STAT = 4'h3,
    PH_MOUT = 4'h6,
    PH_MIN  = 4'h7,
    PH_FREE = 4'h8,
    PH_EXEC = 4'h9
  } seq_ph_t;

  function automatic logic [3:0] cdb_len(input logic [7:0] opcode);
    if (opcode < 8'h20)      cdb_len = 4'd6;
    else if (opcode < 8'hA0) cdb_len = 4'd10;
    else                     cdb_len = 4'd12;
  endfunction

  // REQ|BSY|code image
  function automatic logic [7:0] img_req(input seq_ph_t ph);
    img_req = 8'h88 | {5'd0, ph[2:0]};
  endfunction

  // ACK|BSY|code image
  function automatic logic [7:0] img_ack(input seq_ph_t ph);
    img_ack = 8'h48 | {5'd0, ph[2:0]};
  endfunction

  function automatic seq_ph_t tgt_pick(input logic [2:0] code);
    case (code)
      3'b000:  tgt_pick = PH_DOUT;
      3'b001:  tgt_pick = PH_DIN;
      default: tgt_pick = PH_STAT;
    endcase
  endfunction

endpackage

// File: rtl/seq_gate.sv
`timescale 1ns/1ps
module seq_gate (
  input  logic       set_i,
  input  logic       clr_i,
  input  logic       req_i,
  input  logic       ack_i,
  input  logic       bsy_i,
  input  logic [2:0] cur_code_i,
  input  logic [2:0] exp_code_i,
  output logic       set_go_o,
  output logic       clr_go_o,
  output logic       mismatch_o
);
  logic match;
  logic set_hs;
  logic clr_hs;

  always_comb begin
    match      = (cur_code_i == exp_code_i);
    set_hs     = req_i & bsy_i;
    clr_hs     = ack_i & bsy_i;
    set_go_o   = set_i & set_hs & match;
    clr_go_o   = clr_i & clr_hs & match;
    mismatch_o = ((set_i & set_hs) | (clr_i & clr_hs)) & ~match;
  end
endmodule

// File: rtl/seq_count.sv
`timescale 1ns/1ps
module seq_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             dec_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/seq_cdb_store.sv
`timescale 1ns/1ps
module seq_cdb_store #(
  parameter int DEPTH = 12,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i && (32'(waddr_i) < DEPTH)) mem[waddr_i] <= wdata_i;
    if (32'(raddr_i) < DEPTH) rdata_o <= mem[raddr_i];
    else                      rdata_o <= 8'h00;
  end
endmodule

// File: rtl/scsi_phase_seq.sv
`timescale 1ns/1ps
module scsi_phase_seq
  import scsi_seq_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int CDB_DEPTH = 12,
  localparam int IDX_W    = $clog2(CDB_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             atn_i,
  input  logic             start_i,
  input  logic             release_i,
  input  logic             set_req_i,
  input  logic             clr_req_i,
  input  logic             sense_rd_i,
  input  logic             xfer_active_i,
  input  logic [2:0]       expect_phase_i,
  input  logic [7:0]       wr_byte_i,
  input  logic             tgt_exec_i,
  input  logic [2:0]       tgt_phase_i,
  input  logic [CNT_W-1:0] tgt_count_i,
  input  logic             tgt_more_i,
  input  logic [7:0]       tgt_data_i,
  input  logic [7:0]       tgt_status_i,
  input  logic [7:0]       tgt_msg_i,
  input  logic             tgt_msg_pend_i,
  input  logic [IDX_W-1:0] cdb_raddr_i,
  output logic [7:0]       sense_o,
  output logic [7:0]       rd_byte_o,
  output logic [7:0]       out_byte_o,
  output logic             out_stb_o,
  output logic             in_pop_o,
  output logic             blk_req_o,
  output logic             cmd_done_o,
  output logic             phase_err_o,
  output logic             disc_o,
  output logic [7:0]       cdb_rdata_o
);

  // registered state
  seq_ph_t          st_q, nx_q;
  logic [7:0]       img_q;
  logic             atn_q;
  logic             first_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       rd_q, out_q;
  logic             out_stb_q, pop_q, blk_q, done_q, perr_q, disc_q;

  // next values
  seq_ph_t          st_d, nx_d;
  logic [7:0]       img_d;
  logic             first_d;
  logic [IDX_W-1:0] idx_d;
  logic [7:0]       rd_d, out_d;
  logic             out_stb_d, pop_d, blk_d, done_d, perr_d, disc_d;
  logic             atn_chk;

  // helpers
  logic             set_go, clr_go, mism;
  logic             cnt_load, cnt_dec, cnt_last;
  logic [CNT_W-1:0] cnt_val;
  logic             cdb_we;
  logic [IDX_W-1:0] cdb_wa;
  seq_ph_t          pick;

  seq_gate gate_i (
    .set_i      (set_req_i),
    .clr_i      (clr_req_i),
    .req_i      (img_q[SB_REQ]),
    .ack_i      (img_q[SB_ACK]),
    .bsy_i      (img_q[SB_BSY]),
    .cur_code_i (img_q[2:0]),
    .exp_code_i (expect_phase_i),
    .set_go_o   (set_go),
    .clr_go_o   (clr_go),
    .mismatch_o (mism)
  );

  seq_count #(.CNT_W(CNT_W)) cnt_i (
    .clk    (clk),
    .rst    (rst),
    .load_i (cnt_load),
    .dec_i  (cnt_dec),
    .val_i  (cnt_val),
    .last_o (cnt_last)
  );

  seq_cdb_store #(.DEPTH(CDB_DEPTH), .AW(IDX_W)) cdb_i (
    .clk     (clk),
    .we_i    (cdb_we),
    .waddr_i (cdb_wa),
    .wdata_i (wr_byte_i),
    .raddr_i (cdb_raddr_i),
    .rdata_o (cdb_rdata_o)
  );

  assign pick = tgt_pick(tgt_phase_i);

  always_comb begin
    st_d      = st_q;
    nx_d      = nx_q;
    img_d     = img_q;
    first_d   = first_q;
    idx_d     = idx_q;
    rd_d      = rd_q;
    out_d     = out_q;
    out_stb_d = 1'b0;
    pop_d     = 1'b0;
    blk_d     = 1'b0;
    done_d    = 1'b0;
    perr_d    = 1'b0;
    disc_d    = 1'b0;
    atn_chk   = 1'b0;
    cnt_load  = 1'b0;
    cnt_dec   = 1'b0;
    cnt_val   = tgt_count_i;
    cdb_we    = 1'b0;
    cdb_wa    = first_q ? '0 : idx_q;

    if (release_i) begin
      disc_d = (st_q != PH_FREE);
      st_d   = PH_FREE;
      nx_d   = PH_FREE;
      img_d  = 8'h00;
    end else if (start_i && st_q == PH_FREE) begin
      first_d = 1'b1;
      idx_d   = '0;
      if (atn_q) begin
        st_d  = PH_MOUT;
        nx_d  = PH_CMD;
        img_d = img_req(PH_MOUT);
      end else begin
        st_d  = PH_CMD;
        img_d = img_req(PH_CMD);
      end
    end else if (set_req_i) begin
      if (set_go) begin
        img_d = img_ack(st_q);
        case (st_q)
          PH_DIN: begin
            rd_d  = tgt_data_i;
            pop_d = 1'b1;
          end
          PH_DOUT, PH_MOUT: begin
            out_d     = wr_byte_i;
            out_stb_d = 1'b1;
          end
          PH_CMD: begin
            cdb_we  = 1'b1;
            idx_d   = cdb_wa + 1'b1;
            first_d = 1'b0;
            if (first_q) begin
              cnt_load = 1'b1;
              cnt_val  = CNT_W'(cdb_len(wr_byte_i));
            end
          end
          PH_STAT: rd_d = tgt_status_i;
          PH_MIN:  rd_d = tgt_msg_i;
          default: ;
        endcase
      end else begin
        if (img_q[SB_IO]) rd_d = 8'hFF;
        perr_d = mism & xfer_active_i;
      end
    end else if (clr_req_i) begin
      if (clr_go) begin
        case (st_q)
          PH_DIN, PH_DOUT: begin
            atn_chk = 1'b1;
            if (!cnt_last) begin
              cnt_dec = 1'b1;
              img_d   = img_req(st_q);
            end else if (tgt_more_i) begin
              cnt_load = 1'b1;
              blk_d    = 1'b1;
              img_d    = img_req(st_q);
            end else begin
              st_d  = PH_STAT;
              img_d = img_req(PH_STAT);
            end
          end
          PH_CMD: begin
            if (!cnt_last) begin
              cnt_dec = 1'b1;
              img_d   = img_req(PH_CMD);
              atn_chk = 1'b1;
            end else begin
              done_d = 1'b1;
              if (tgt_exec_i) begin
                st_d  = PH_EXEC;
                img_d = 8'h08;
              end else begin
                st_d     = pick;
                cnt_load = 1'b1;
                img_d    = img_req(pick);
                atn_chk  = 1'b1;
              end
            end
          end
          PH_STAT: begin
            st_d    = PH_MIN;
            img_d   = img_req(PH_MIN);
            atn_chk = 1'b1;
          end
          PH_MIN: begin
            if (!tgt_msg_pend_i) begin
              st_d   = PH_FREE;
              nx_d   = PH_FREE;
              img_d  = 8'h00;
              disc_d = 1'b1;
            end else begin
              img_d   = img_req(PH_MIN);
              atn_chk = 1'b1;
            end
          end
          PH_MOUT: begin
            if (atn_q) begin
              img_d = img_req(PH_MOUT);
            end else begin
              st_d  = nx_q;
              nx_d  = PH_FREE;
              img_d = img_req(nx_q);
            end
          end
          default: ;
        endcase
      end else begin
        perr_d = mism & xfer_active_i;
      end
    end else if (sense_rd_i && st_q == PH_EXEC && !tgt_exec_i) begin
      st_d     = pick;
      cnt_load = 1'b1;
      img_d    = img_req(pick);
      atn_chk  = 1'b1;
    end

    // ATN diverts the freshly entered phase into message-out
    if (atn_chk && atn_q) begin
      nx_d  = st_d;
      st_d  = PH_MOUT;
      img_d = img_req(PH_MOUT);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= PH_FREE;
      nx_q      <= PH_FREE;
      img_q     <= 8'h00;
      atn_q     <= 1'b0;
      first_q   <= 1'b1;
      idx_q     <= '0;
      rd_q      <= 8'h00;
      out_q     <= 8'h00;
      out_stb_q <= 1'b0;
      pop_q     <= 1'b0;
      blk_q     <= 1'b0;
      done_q    <= 1'b0;
      perr_q    <= 1'b0;
      disc_q    <= 1'b0;
    end else begin
      st_q      <= st_d;
      nx_q      <= nx_d;
      img_q     <= img_d;
      atn_q     <= atn_i;
      first_q   <= first_d;
      idx_q     <= idx_d;
      rd_q      <= rd_d;
      out_q     <= out_d;
      out_stb_q <= out_stb_d;
      pop_q     <= pop_d;
      blk_q     <= blk_d;
      done_q    <= done_d;
      perr_q    <= perr_d;
      disc_q    <= disc_d;
    end
  end

  assign sense_o     = img_q | {2'b00, atn_q, 5'b00000};
  assign rd_byte_o   = rd_q;
  assign out_byte_o  = out_q;
  assign out_stb_o   = out_stb_q;
  assign in_pop_o    = pop_q;
  assign blk_req_o   = blk_q;
  assign cmd_done_o  = done_q;
  assign phase_err_o = perr_q;
  assign disc_o      = disc_q;

endmodule

// File: rtl/scsi_phase_seq_chk.sv
`timescale 1ns/1ps
module scsi_phase_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       set_req_i,
  input logic       clr_req_i,
  input logic       xfer_active_i,
  input logic [7:0] sense_o,
  input logic       out_stb_o,
  input logic       phase_err_o,
  input logic       disc_o,
  input logic       cmd_done_o
);
  a_r2_req_ack_excl: assert property (@(posedge clk) disable iff (rst)
    !(sense_o[7] && sense_o[6]));

  a_r4_ack_from_set: assert property (@(posedge clk) disable iff (rst)
    $rose(sense_o[6]) |-> $past(set_req_i));

  a_r5_perr_in_xfer: assert property (@(posedge clk) disable iff (rst)
    phase_err_o |-> $past(xfer_active_i));

  a_r6_done_from_clr: assert property (@(posedge clk) disable iff (rst)
    cmd_done_o |-> $past(clr_req_i));

  a_r9_disc_clears_sense: assert property (@(posedge clk) disable iff (rst)
    disc_o |-> ((sense_o & 8'hDF) == 8'h00));

  a_r11_out_from_set: assert property (@(posedge clk) disable iff (rst)
    out_stb_o |-> $past(set_req_i));
endmodule

bind scsi_phase_seq scsi_phase_seq_chk chk_i (
  .clk           (clk),
  .rst           (rst),
  .set_req_i     (set_req_i),
  .clr_req_i     (clr_req_i),
  .xfer_active_i (xfer_active_i),
  .sense_o       (sense_o),
  .out_stb_o     (out_stb_o),
  .phase_err_o   (phase_err_o),
  .disc_o        (disc_o),
  .cmd_done_o    (cmd_done_o)
);

// File: tb/scsi_phase_seq_tb.sv
`timescale 1ns/1ps
module scsi_phase_seq_tb_top;
  localparam int CNT_W = 16;
  localparam int IDX_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic atn_i = 0, start_i = 0, release_i = 0, set_req_i = 0, clr_req_i = 0;
  logic sense_rd_i = 0, xfer_active_i = 0;
  logic [2:0] expect_phase_i = 3'b000;
  logic [7:0] wr_byte_i = 8'h00;
  logic tgt_exec_i = 0;
  logic [2:0] tgt_phase_i = 3'b011;
  logic [CNT_W-1:0] tgt_count_i = 1;
  logic tgt_more_i = 0;
  logic [7:0] tgt_data_i = 0, tgt_status_i = 0, tgt_msg_i = 0;
  logic tgt_msg_pend_i = 0;
  logic [IDX_W-1:0] cdb_raddr_i = 0;
  logic [7:0] sense_o, rd_byte_o, out_byte_o, cdb_rdata_o;
  logic out_stb_o, in_pop_o, blk_req_o, cmd_done_o, phase_err_o, disc_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  scsi_phase_seq dut_i (
    .clk(clk), .rst(rst), .atn_i(atn_i), .start_i(start_i), .release_i(release_i),
    .set_req_i(set_req_i), .clr_req_i(clr_req_i), .sense_rd_i(sense_rd_i),
    .xfer_active_i(xfer_active_i), .expect_phase_i(expect_phase_i),
    .wr_byte_i(wr_byte_i), .tgt_exec_i(tgt_exec_i), .tgt_phase_i(tgt_phase_i),
    .tgt_count_i(tgt_count_i), .tgt_more_i(tgt_more_i), .tgt_data_i(tgt_data_i),
    .tgt_status_i(tgt_status_i), .tgt_msg_i(tgt_msg_i),
    .tgt_msg_pend_i(tgt_msg_pend_i), .cdb_raddr_i(cdb_raddr_i),
    .sense_o(sense_o), .rd_byte_o(rd_byte_o), .out_byte_o(out_byte_o),
    .out_stb_o(out_stb_o), .in_pop_o(in_pop_o), .blk_req_o(blk_req_o),
    .cmd_done_o(cmd_done_o), .phase_err_o(phase_err_o), .disc_o(disc_o),
    .cdb_rdata_o(cdb_rdata_o)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_set(input logic [7:0] b);
    wr_byte_i = b; set_req_i = 1'b1; tick(); set_req_i = 1'b0;
  endtask

  task automatic do_clr();
    clr_req_i = 1'b1; tick(); clr_req_i = 1'b0;
  endtask

  task automatic do_start();
    start_i = 1'b1; tick(); start_i = 1'b0;
  endtask

  task automatic do_release();
    release_i = 1'b1; tick(); release_i = 1'b0;
  endtask

  task automatic do_sense_rd();
    sense_rd_i = 1'b1; tick(); sense_rd_i = 1'b0;
  endtask

  // sends a whole command; checks length via cmd_done timing (R6)
  task automatic send_cmd(input logic [7:0] op, input int len, input logic [7:0] last_img);
    expect_phase_i = 3'b010;
    for (int i = 0; i < len; i++) begin
      do_set((i == 0) ? op : 8'(i));
      chk("R4", "ack image in command", sense_o, 8'h4A);
      do_clr();
      if (i < len - 1) begin
        chk("R6", "command still running", {7'd0, cmd_done_o}, 8'h00);
        chk("R6", "command REQ image", sense_o, 8'h8A);
      end else begin
        chk("R6", "cmd_done at last byte", {7'd0, cmd_done_o}, 8'h01);
        chk("R7", "image after command", sense_o, last_img);
      end
    end
  endtask

  task automatic t_reset();
    chk("R1", "sense after reset", sense_o, 8'h00);
    chk("R1", "rd_byte after reset", rd_byte_o, 8'h00);
    chk("R1", "pulses after reset",
        {2'b0, out_stb_o, in_pop_o, blk_req_o, cmd_done_o, phase_err_o, disc_o}, 8'h00);
    atn_i = 1'b1; tick();
    chk("R2", "ATN in bit 5", sense_o, 8'h20);
    atn_i = 1'b0; tick();
    chk("R2", "ATN dropped", sense_o, 8'h00);
  endtask

  task automatic t_six_byte_read();
    do_start();
    chk("R3", "command entry", sense_o, 8'h8A);
    expect_phase_i = 3'b000; xfer_active_i = 1'b1;
    do_set(8'h12);
    chk("R5", "mismatch phase error", {7'd0, phase_err_o}, 8'h01);
    chk("R4", "refused set keeps image", sense_o, 8'h8A);
    xfer_active_i = 1'b0;
    tgt_exec_i = 0; tgt_phase_i = 3'b001; tgt_count_i = 3; tgt_more_i = 0;
    send_cmd(8'h12, 6, 8'h89);
    for (int a = 0; a < 6; a++) begin
      cdb_raddr_i = 4'(a); tick();
      chk("R6", "stored command byte", cdb_rdata_o, (a == 0) ? 8'h12 : 8'(a));
    end
    expect_phase_i = 3'b001;
    for (int i = 0; i < 3; i++) begin
      tgt_data_i = 8'hA0 + 8'(i);
      do_set(8'h00);
      chk("R11", "data-in byte", rd_byte_o, 8'hA0 + 8'(i));
      chk("R11", "in_pop pulse", {7'd0, in_pop_o}, 8'h01);
      chk("R4", "data-in ack image", sense_o, 8'h49);
      do_clr();
      chk("R8", "data-in step", sense_o, (i < 2) ? 8'h89 : 8'h8B);
    end
    expect_phase_i = 3'b000;
    do_set(8'h00);
    chk("R4", "inbound refusal returns FF", rd_byte_o, 8'hFF);
    expect_phase_i = 3'b011; tgt_status_i = 8'h02;
    do_set(8'h00);
    chk("R11", "status byte", rd_byte_o, 8'h02);
    do_clr();
    chk("R9", "status to message-in", sense_o, 8'h8F);
    expect_phase_i = 3'b111; tgt_msg_i = 8'h00;
    do_set(8'h33);
    chk("R11", "message byte", rd_byte_o, 8'h00);
    do_clr();
    chk("R9", "disconnect image", sense_o, 8'h00);
    chk("R9", "disc pulse", {7'd0, disc_o}, 8'h01);
  endtask

  task automatic t_exec_write();
    do_start();
    tgt_exec_i = 1'b1;
    send_cmd(8'h20, 10, 8'h08);
    do_sense_rd();
    chk("R7", "still executing", sense_o, 8'h08);
    tgt_exec_i = 1'b0; tgt_phase_i = 3'b000; tgt_count_i = 2;
    do_sense_rd();
    chk("R7", "resolved to data-out", sense_o, 8'h88);
    expect_phase_i = 3'b000;
    do_set(8'h55);
    chk("R11", "data-out byte", out_byte_o, 8'h55);
    chk("R11", "out strobe", {7'd0, out_stb_o}, 8'h01);
    do_clr();
    chk("R8", "mid block", sense_o, 8'h88);
    tgt_more_i = 1'b1; tgt_count_i = 1;
    do_set(8'h66);
    do_clr();
    chk("R8", "next block requested", {7'd0, blk_req_o}, 8'h01);
    chk("R8", "stays data-out", sense_o, 8'h88);
    tgt_more_i = 1'b0;
    do_set(8'h77);
    chk("R11", "third data-out byte", out_byte_o, 8'h77);
    do_clr();
    chk("R8", "to status", sense_o, 8'h8B);
    do_release();
    chk("R9", "release image", sense_o, 8'h00);
    chk("R9", "release disc", {7'd0, disc_o}, 8'h01);
  endtask

  task automatic t_twelve_byte();
    do_start();
    tgt_exec_i = 0; tgt_phase_i = 3'b011;
    send_cmd(8'hA0, 12, 8'h8B);
    do_release();
  endtask

  task automatic t_atn_divert();
    do_start();
    tgt_phase_i = 3'b001; tgt_count_i = 2; tgt_more_i = 0;
    send_cmd(8'h1F, 6, 8'h89);
    expect_phase_i = 3'b001; tgt_data_i = 8'h31;
    do_set(8'h00);
    chk("R11", "first data-in byte", rd_byte_o, 8'h31);
    atn_i = 1'b1; tick();
    do_clr();
    chk("R10", "divert to message-out", sense_o, 8'hAE);
    expect_phase_i = 3'b110;
    do_set(8'h07);
    chk("R10", "message-out byte", out_byte_o, 8'h07);
    chk("R10", "message-out ack", sense_o, 8'h6E);
    atn_i = 1'b0; tick();
    do_clr();
    chk("R10", "resume data-in", sense_o, 8'h89);
    expect_phase_i = 3'b001; tgt_data_i = 8'h32;
    do_set(8'h00);
    expect_phase_i = 3'b000; xfer_active_i = 1'b1;
    do_clr();
    chk("R5", "clear mismatch error", {7'd0, phase_err_o}, 8'h01);
    chk("R5", "clear mismatch keeps image", sense_o, 8'h49);
    xfer_active_i = 1'b0; expect_phase_i = 3'b001;
    do_clr();
    chk("R10", "remaining count kept", sense_o, 8'h8B);
    do_release();
  endtask

  task automatic t_start_atn();
    atn_i = 1'b1; tick();
    do_start();
    chk("R3", "start with ATN", sense_o, 8'hAE);
    expect_phase_i = 3'b110;
    do_set(8'h80);
    chk("R3", "identify byte out", out_byte_o, 8'h80);
    atn_i = 1'b0; tick();
    do_clr();
    chk("R3", "resume command", sense_o, 8'h8A);
    expect_phase_i = 3'b010;
    do_clr();
    chk("R5", "clear without ACK ignored", sense_o, 8'h8A);
    do_release();
    chk("R9", "final release", {7'd0, disc_o}, 8'h01);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_six_byte_read();
    t_exec_write();
    t_twelve_byte();
    t_atn_divert();
    t_start_atn();
    repeat (2) tick();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end
endmodule